// File: doc/BRIEF.md
# MESI Snooping Cache Line Controller

This block keeps one cache line coherent with the other caches on a shared snooping bus. The line holds a two-bit coherence state, an address tag and one data word. A processor presents a read or a write and holds it until a one-cycle done strobe returns. Read hits and writes to an owned line finish without the bus. Misses fetch the line with a shared read or an exclusive read. A write to a line that other caches may also hold broadcasts an invalidate, called the upgrade operation here.

The controller watches every transaction that other caches place on the bus. In the same cycle it answers with a shared indication when it holds a clean copy. It answers with a retry when it holds the only up-to-date copy. A retry is followed in the next cycle by a write-back of the dirty word to memory, and the line then drops to Shared or Invalid. A request of its own that is answered with retry is abandoned. After a fixed back-off delay the controller decides again and reissues it.

Arbitration, memory and indexing of several lines lie outside the block. The bus is taken to carry one transaction per cycle, and the requester samples the shared, retry and read-data inputs in the same cycle as its request.

Top module: `mesi_line_ctrl`

## Requirements
- R1: `line_state_o` uses the encoding Invalid=00, Shared=01, Exclusive=10, Modified=11. After reset it reads 00, and `cpu_done_o`, `bus_wb_o` and `bus_op_o` are all zero. Bus operation codes are none=0, read=1, exclusive read=2, upgrade=3.
- R2: A read that misses (the line is Invalid or the tag differs) drives a read on `bus_op_o` with the requested address for one cycle. The line is filled from `bus_rdata_i` in that cycle. It becomes Exclusive if `bus_shared_i` was low and Shared if it was high. In the next cycle `cpu_done_o` pulses with the filled word on `cpu_rdata_o`.
- R3: A read hit in Shared, Exclusive or Modified puts nothing on the bus. It returns the stored word with `cpu_done_o` one cycle after the request is taken, and leaves the state unchanged.
- R4: A write hit in Exclusive or Modified puts nothing on the bus. It stores the new word and leaves the line Modified.
- R5: A write hit in Shared drives the upgrade operation on `bus_op_o`. The line then becomes Modified and holds the new word.
- R6: A write miss drives an exclusive read. The line then becomes Modified and holds the written word, with the requested tag.
- R7: A snooped read to the held address in Exclusive or Shared raises `snp_shared_o` in the same cycle, and the line becomes Shared. A snooped operation to another address, or to an Invalid line, raises no response and changes nothing.
- R8: A snooped exclusive read or upgrade to the held address in Exclusive or Shared moves the line to Invalid without raising `snp_shared_o`.
- R9: Any snooped operation to the held address in Modified raises `snp_retry_o` in the same cycle. In the next cycle `bus_wb_o` is high, with the tag on `bus_addr_o` and the word on `bus_wdata_o`. The line then becomes Shared after a snooped read, and Invalid after anything else.
- R10: When `bus_retry_i` is high during the controller's own read or exclusive read, no fill takes place and no done strobe is produced. The same request appears again exactly BACKOFF+2 cycles after the retried cycle.
- R11: When a snooped operation that hits the line arrives in the same cycle that a new processor request would be taken, the snoop is applied first. The processor request is then evaluated against the updated state.
- R12: A miss while the line is Modified for another address first writes that word back (`bus_wb_o` with the old tag and data), and only afterwards issues the read or exclusive read.
- R13: `cpu_done_o` is high for exactly one cycle per completed request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_i | input | 1 | Processor request, held until done |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | ADDR_W | Request address |
| cpu_wdata_i | input | DATA_W | Write data |
| cpu_rdata_o | output | DATA_W | Read data, valid with done |
| cpu_done_o | output | 1 | One-cycle completion strobe |
| bus_op_o | output | 2 | Outbound operation: 0 none, 1 read, 2 exclusive read, 3 upgrade |
| bus_wb_o | output | 1 | Write-back of the held word this cycle |
| bus_addr_o | output | ADDR_W | Address of the outbound operation or write-back |
| bus_wdata_o | output | DATA_W | Write-back data |
| bus_rdata_i | input | DATA_W | Fill data for an outbound read |
| bus_shared_i | input | 1 | Another cache holds the requested address |
| bus_retry_i | input | 1 | Another cache aborts this request |
| snp_op_i | input | 2 | Operation by another cache, same coding as bus_op_o |
| snp_addr_i | input | ADDR_W | Address of the snooped operation |
| snp_shared_o | output | 1 | Clean copy held for a snooped read |
| snp_retry_o | output | 1 | Dirty copy held; the snooped operation must be retried |
| line_state_o | output | 2 | Current coherence state |

## Verification
The hardest cases are the ones where two events meet. One is a snoop arriving in the same cycle as a processor write to an Exclusive line. A design that served the processor first would finish the write locally and never broadcast the upgrade. Another is a miss that evicts a Modified word. Skipping the victim write-back loses the dirty data, and reading before it lets the word reach memory late. Retried requests are timed cycle by cycle, so a back-off counter off by one shows up as a reissue in the wrong cycle. A fill after a retry shows up as an early done. Random interleavings of snoops and processor accesses over three addresses are checked against a reference model of state, tag, data and memory. They catch wrong destination states, such as a dirty line falling to Shared after an exclusive read, or a clean line answering shared on an invalidate.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } line_st_t;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_RDX  = 2'd2,
    OP_UPG  = 2'd3
  } bus_op_t;

  typedef enum logic [1:0] {
    C_IDLE,
    C_ISSUE,
    C_BACKOFF,
    C_WB
  } ctrl_t;

  // State of a freshly filled line after a read
  function automatic line_st_t fill_state(input logic shared_seen);
    return shared_seen ? ST_S : ST_E;
  endfunction

  // State after a snooped operation hits the line (write-back handled separately)
  function automatic line_st_t snoop_next(input line_st_t st, input bus_op_t op);
    if (st == ST_I || op == OP_NONE) return st;
    if (op == OP_RD) return ST_S;
    return ST_I;
  endfunction

endpackage

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  line_st_t           st,
  input  logic [ADDR_W-1:0]  tag,
  input  bus_op_t            snp_op,
  input  logic [ADDR_W-1:0]  snp_addr,
  output logic               hit,
  output logic               shared_rsp,
  output logic               retry_rsp
);

  always_comb begin
    hit        = (snp_op != OP_NONE) && (st != ST_I) && (tag == snp_addr);
    shared_rsp = hit && (snp_op == OP_RD) && (st == ST_E || st == ST_S);
    retry_rsp  = hit && (st == ST_M);
  end

endmodule

// File: rtl/mesi_backoff.sv
module mesi_backoff #(
  parameter int CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expire
);

  localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          active_q;

  assign expire = active_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      cnt_q    <= CW'(CYCLES - 1);
    end else if (expire) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int BACKOFF = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              cpu_done_o,
  output logic [1:0]        bus_op_o,
  output logic              bus_wb_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_shared_i,
  input  logic              bus_retry_i,
  input  logic [1:0]        snp_op_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              snp_shared_o,
  output logic              snp_retry_o,
  output logic [1:0]        line_state_o
);

  line_st_t          st_q, wb_next_q;
  logic [ADDR_W-1:0] tag_q;
  logic [DATA_W-1:0] data_q, rdata_q;
  ctrl_t             ctrl_q;
  bus_op_t           op_q;
  logic              done_q;

  // Named internal events
  logic snp_hit, snoop_act, cpu_hit, accept;
  logic issue_retry, issue_ok, bo_expire;
  bus_op_t snp_op;

  assign snp_op = bus_op_t'(snp_op_i);

  mesi_snoop_resp #(.ADDR_W(ADDR_W)) u_resp (
    .st         (st_q),
    .tag        (tag_q),
    .snp_op     (snp_op),
    .snp_addr   (snp_addr_i),
    .hit        (snp_hit),
    .shared_rsp (snp_shared_o),
    .retry_rsp  (snp_retry_o)
  );

  mesi_backoff #(.CYCLES(BACKOFF)) u_backoff (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (issue_retry),
    .expire (bo_expire)
  );

  always_comb begin
    snoop_act   = snp_hit && (ctrl_q == C_IDLE || ctrl_q == C_BACKOFF);
    cpu_hit     = (st_q != ST_I) && (tag_q == cpu_addr_i);
    accept      = (ctrl_q == C_IDLE) && cpu_req_i && !done_q && !snoop_act;
    issue_retry = (ctrl_q == C_ISSUE) && bus_retry_i;
    issue_ok    = (ctrl_q == C_ISSUE) && !bus_retry_i;
  end

  assign bus_op_o     = (ctrl_q == C_ISSUE) ? op_q : OP_NONE;
  assign bus_wb_o     = (ctrl_q == C_WB);
  assign bus_addr_o   = (ctrl_q == C_WB) ? tag_q : cpu_addr_i;
  assign bus_wdata_o  = data_q;
  assign cpu_rdata_o  = rdata_q;
  assign cpu_done_o   = done_q;
  assign line_state_o = st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_I;
      wb_next_q <= ST_I;
      tag_q     <= '0;
      data_q    <= '0;
      rdata_q   <= '0;
      ctrl_q    <= C_IDLE;
      op_q      <= OP_NONE;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (snoop_act) begin
        if (st_q == ST_M) begin
          ctrl_q    <= C_WB;
          wb_next_q <= (snp_op == OP_RD) ? ST_S : ST_I;
        end else begin
          st_q <= snoop_next(st_q, snp_op);
          if (ctrl_q == C_BACKOFF && bo_expire) ctrl_q <= C_IDLE;
        end
      end else begin
        case (ctrl_q)
          C_IDLE: begin
            if (accept) begin
              if (cpu_hit) begin
                if (!cpu_we_i) begin
                  rdata_q <= data_q;
                  done_q  <= 1'b1;
                end else if (st_q == ST_S) begin
                  op_q   <= OP_UPG;
                  ctrl_q <= C_ISSUE;
                end else begin
                  data_q <= cpu_wdata_i;
                  st_q   <= ST_M;
                  done_q <= 1'b1;
                end
              end else if (st_q == ST_M) begin
                wb_next_q <= ST_I;
                ctrl_q    <= C_WB;
              end else begin
                op_q   <= cpu_we_i ? OP_RDX : OP_RD;
                ctrl_q <= C_ISSUE;
              end
            end
          end
          C_ISSUE: begin
            if (issue_ok) begin
              tag_q  <= cpu_addr_i;
              done_q <= 1'b1;
              ctrl_q <= C_IDLE;
              if (op_q == OP_RD) begin
                data_q  <= bus_rdata_i;
                rdata_q <= bus_rdata_i;
                st_q    <= fill_state(bus_shared_i);
              end else begin
                data_q <= cpu_wdata_i;
                st_q   <= ST_M;
              end
            end else begin
              ctrl_q <= C_BACKOFF;
            end
          end
          C_BACKOFF: if (bo_expire) ctrl_q <= C_IDLE;
          C_WB: begin
            st_q   <= wb_next_q;
            ctrl_q <= C_IDLE;
          end
          default: ctrl_q <= C_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/mesi_line_chk.sv
module mesi_line_chk
  import mesi_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] line_state_o,
  input logic [1:0] bus_op_o,
  input logic       bus_wb_o,
  input logic       bus_retry_i,
  input logic       bus_shared_i,
  input logic       snp_shared_o,
  input logic       snp_retry_o,
  input logic       cpu_done_o,
  input logic       snoop_act
);

  // R9
  dirty_snoop_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_act && line_state_o == ST_M) |=> bus_wb_o);

  // R9
  wb_leaves_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wb_o |=> (line_state_o == ST_S || line_state_o == ST_I));

  // R2
  read_fill_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_op_o == OP_RD && !bus_retry_i) |=>
      (line_state_o == ($past(bus_shared_i) ? ST_S : ST_E)));

  // R6
  excl_fill_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_op_o == OP_RDX || bus_op_o == OP_UPG) && !bus_retry_i) |=> line_state_o == ST_M);

  // R10
  retry_aborts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_op_o != OP_NONE && bus_retry_i) |=> (bus_op_o == OP_NONE && !cpu_done_o));

  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done_o |=> !cpu_done_o);

  // R7
  rsp_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(snp_shared_o && snp_retry_o));

endmodule

bind mesi_line_ctrl mesi_line_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .line_state_o (line_state_o),
  .bus_op_o     (bus_op_o),
  .bus_wb_o     (bus_wb_o),
  .bus_retry_i  (bus_retry_i),
  .bus_shared_i (bus_shared_i),
  .snp_shared_o (snp_shared_o),
  .snp_retry_o  (snp_retry_o),
  .cpu_done_o   (cpu_done_o),
  .snoop_act    (snoop_act)
);

// File: tb/tb_mesi_line_ctrl.sv
module tb_mesi_line_ctrl;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int BO = 8;

  localparam logic [1:0] SI = 2'b00, SS = 2'b01, SE = 2'b10, SM = 2'b11;
  localparam logic [1:0] ONONE = 2'd0, ORD = 2'd1, ORDX = 2'd2, OUPG = 2'd3;
  localparam logic [AW-1:0] A_ADR = 16'h0040, B_ADR = 16'h0081, C_ADR = 16'h00C2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req_i = 1'b0, cpu_we_i = 1'b0;
  logic [AW-1:0] cpu_addr_i = '0;
  logic [DW-1:0] cpu_wdata_i = '0;
  logic [DW-1:0] cpu_rdata_o;
  logic cpu_done_o;
  logic [1:0] bus_op_o;
  logic bus_wb_o;
  logic [AW-1:0] bus_addr_o;
  logic [DW-1:0] bus_wdata_o;
  logic [DW-1:0] bus_rdata_i = '0;
  logic bus_shared_i = 1'b0, bus_retry_i = 1'b0;
  logic [1:0] snp_op_i = 2'd0;
  logic [AW-1:0] snp_addr_i = '0;
  logic snp_shared_o, snp_retry_o;
  logic [1:0] line_state_o;

  always #2.5 clk = ~clk;

  mesi_line_ctrl #(.ADDR_W(AW), .DATA_W(DW), .BACKOFF(BO)) dut (.*);

  int checks = 0;
  int errors = 0;
  bit done_run = 0;

  // Reference model
  logic [1:0]    m_st = SI;
  logic [AW-1:0] m_tag = '0;
  logic [DW-1:0] m_data = '0;
  logic [DW-1:0] mem [4];

  function automatic logic [1:0] exp_snoop_state(logic [1:0] st, logic [1:0] op);
    if (st == SI || op == ONONE) return st;
    return (op == ORD) ? SS : SI;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Processor access; pre_snp drives a snoop in the same cycle as the request
  task automatic cpu_op(bit we, logic [AW-1:0] addr, logic [DW-1:0] wd, bit shr, bit rty,
                        logic [1:0] pre_snp, string req);
    bit hit, victim, got_done;
    logic [1:0] exp_op;
    int n_iss, t_rty;
    n_iss = 0; t_rty = 0; got_done = 0;
    @(negedge clk);
    if (pre_snp != ONONE) begin
      snp_op_i = pre_snp; snp_addr_i = addr;
      if (m_st != SI && m_tag == addr && m_st != SM) m_st = exp_snoop_state(m_st, pre_snp);
    end
    hit    = (m_st != SI) && (m_tag == addr);
    victim = !hit && (m_st == SM);
    exp_op = hit ? ((we && m_st == SS) ? OUPG : ONONE) : (we ? ORDX : ORD);
    cpu_req_i = 1'b1; cpu_we_i = we; cpu_addr_i = addr; cpu_wdata_i = wd;
    for (int cyc = 0; cyc < 60; cyc++) begin
      @(negedge clk);
      snp_op_i = ONONE; bus_shared_i = 0; bus_retry_i = 0;
      if (cpu_done_o) begin got_done = 1; break; end
      if (bus_wb_o) begin
        chk(victim && bus_addr_o == m_tag && bus_wdata_o == m_data && n_iss == 0, "R12",
            "victim write-back", {bus_addr_o, bus_wdata_o}, {m_tag, m_data});
        mem[m_tag[1:0]] = m_data;
        m_st = SI;
      end
      if (bus_op_o != ONONE) begin
        n_iss++;
        chk(bus_op_o == exp_op && bus_addr_o == addr, req, "bus op", bus_op_o, exp_op);
        if (rty && exp_op != OUPG && n_iss == 1) begin
          bus_retry_i = 1; t_rty = cyc;
        end else begin
          if (rty && exp_op != OUPG)
            chk(cyc - t_rty == BO + 2, "R10", "reissue gap", cyc - t_rty, BO + 2);
          bus_shared_i = shr;
          bus_rdata_i  = mem[addr[1:0]];
        end
      end
    end
    chk(got_done, req, "done seen", got_done, 1);
    if (exp_op == ONONE) chk(n_iss == 0, req, "no bus op", n_iss, 0);
    if (we) begin
      m_data = wd; m_st = SM; m_tag = addr;
    end else begin
      if (!hit) begin m_data = mem[addr[1:0]]; m_st = shr ? SS : SE; m_tag = addr; end
      chk(cpu_rdata_o == m_data, req, "read data", cpu_rdata_o, m_data);
    end
    chk(line_state_o == m_st, req, "state after access", line_state_o, m_st);
    cpu_req_i = 1'b0;
    @(negedge clk);
    chk(!cpu_done_o, "R13", "done one cycle", cpu_done_o, 0);
  endtask

  task automatic snoop_op(logic [1:0] op, logic [AW-1:0] addr, string req);
    bit hit, e_sh, e_rt;
    @(negedge clk);
    snp_op_i = op; snp_addr_i = addr;
    hit  = (m_st != SI) && (m_tag == addr);
    e_sh = hit && op == ORD && (m_st == SE || m_st == SS);
    e_rt = hit && m_st == SM;
    #1;
    chk(snp_shared_o == e_sh, req, "shared response", snp_shared_o, e_sh);
    chk(snp_retry_o == e_rt, "R9", "retry response", snp_retry_o, e_rt);
    @(negedge clk);
    snp_op_i = ONONE;
    if (e_rt) begin
      chk(bus_wb_o && bus_addr_o == m_tag && bus_wdata_o == m_data, "R9", "snoop write-back",
          {bus_wb_o, bus_addr_o, bus_wdata_o}, {1'b1, m_tag, m_data});
      mem[m_tag[1:0]] = m_data;
      m_st = (op == ORD) ? SS : SI;
      @(negedge clk);
    end else if (hit) begin
      m_st = exp_snoop_state(m_st, op);
    end
    chk(line_state_o == m_st, req, "state after snoop", line_state_o, m_st);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done_run) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 4; i++) mem[i] = 32'h1000_0000 + i;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(line_state_o == SI && !cpu_done_o && bus_op_o == ONONE && !bus_wb_o, "R1", "reset",
        {line_state_o, cpu_done_o, bus_op_o, bus_wb_o}, 0);
    rst_n = 1'b1;

    cpu_op(0, A_ADR, 0, 0, 0, ONONE, "R2");            // miss, fill E
    cpu_op(0, A_ADR, 0, 0, 0, ONONE, "R3");            // read hit
    snoop_op(ORD, A_ADR, "R7");                        // E -> S with shared
    snoop_op(ORD, B_ADR, "R7");                        // other address: nothing
    cpu_op(1, A_ADR, 32'hAAAA_0001, 0, 0, ONONE, "R5"); // upgrade
    cpu_op(1, A_ADR, 32'hAAAA_0002, 0, 0, ONONE, "R4"); // local write
    snoop_op(ORD, A_ADR, "R9");                        // M -> retry, wb, S
    snoop_op(ORDX, A_ADR, "R8");                       // S -> I
    cpu_op(0, A_ADR, 0, 1, 0, ONONE, "R2");            // fill S
    cpu_op(1, B_ADR, 32'hBBBB_0001, 0, 0, ONONE, "R6"); // write miss
    cpu_op(0, A_ADR, 0, 0, 1, ONONE, "R12");           // victim wb, then retried read
    cpu_op(1, A_ADR, 32'hAAAA_0003, 0, 0, ORD, "R11");  // snoop first -> upgrade
    snoop_op(OUPG, A_ADR, "R9");                       // M -> retry, wb, I
    cpu_op(1, C_ADR, 32'hCCCC_0001, 0, 1, ONONE, "R10"); // retried exclusive read

    for (int n = 0; n < 150; n++) begin
      int pick;
      logic [AW-1:0] ad;
      pick = $urandom % 3;
      case ($urandom % 3)
        0: ad = A_ADR;
        1: ad = B_ADR;
        default: ad = C_ADR;
      endcase
      if (pick == 0) snoop_op(2'(1 + $urandom % 3), ad, "R8");
      else cpu_op(1'($urandom % 2), ad, $urandom, 1'($urandom % 2), ($urandom % 4) == 0,
                  ONONE, "R2");
    end

    done_run = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule